// File: doc/BRIEF.md
# Segmented Address Translation Checker

This block turns a selector:offset pair into a 32-bit linear address. It also reports how many bytes can be reached from that address before the segment ends, or it returns an error code. It holds two small descriptor tables, a global one and a local one. Each table is loaded one 32-bit word at a time through a shared write port.

A request can supply a hidden descriptor cache: a base, a limit and attributes already known to the requester. When that cache is valid, the cached values are used and the tables are not read. A real/virtual-8086 mode flag selects the simple paragraph translation, which skips every descriptor check.

The block checks that the selector lies inside its table, that the descriptor is present, that its type is legal and that the offset is within the limit. The limit rule depends on the segment type. Privilege levels are not checked. The result appears one clock after the request strobe.

Top module: `seg_xlate`

## Requirements
- R1: When `realMode` is set, the linear address is `reqOffset[15:0]` plus either `hidBase` (if `hidValid` is set) or `reqSel` shifted left by 4, taken modulo 2^32. The remaining count is 0x10000 minus `reqOffset[15:0]`, and the error code is always 0.
- R2: Outside real mode and without a valid hidden cache, selector bit 2 picks the table: 1 is the local table and 0 is the global table. The entry index is `reqSel >> 3`, taken modulo ENTRIES (32).
- R3: Let the masked selector be `reqSel` with bits 2:0 cleared. If the masked selector is greater than or equal to the active table's byte limit (`ldtBytes` or `gdtBytes`), the result is error 1. `tblBypass` skips this check for the global table only.
- R4: A table descriptor is two 32-bit words.
  - The low word holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16.
  - The high word holds base[23:16] in bits 7:0, the type in bits 11:8, the descriptor-type bit S in bit 12, the present bit P in bit 15, limit[19:16] in bits 19:16, the granularity bit G in bit 23 and base[31:24] in bits 31:24.
  - The linear address is base plus offset, modulo 2^32.
  - When G is set, the effective limit is (raw20 << 12) | 0xFFF. Otherwise it is raw20.
- R5: A descriptor whose present bit is clear gives error 2. This check comes before any type or limit check.
- R6: This rule covers S=1 with type bit 3 set (code) and S=1 with type bits 3:2 equal to 00 (expand-up data). An offset above the effective limit is error 3. Otherwise the remaining count is limit − offset + 1.
- R7: This rule covers expand-down data: S=1 with type bits 3:2 equal to 01. Error 3 is raised if G is clear and the offset is above 0xFFFF, or if the offset is less than or equal to the limit. Otherwise the remaining count is (0xFFFFFFFF if G is set, else 0xFFFF) − offset + 1.
- R8: For S=0, the types 0x0, 0x8, 0xA and 0xD are error 1. Every other system type follows the limit check of R6, but its remaining count is 2^32 minus the linear address.
- R9: When `hidValid` is set outside real mode, the fields of `hidAttr` are used in place of the table descriptor, and the tables are not consulted.
  - `hidAttr` fields: [6] granularity, [5] present, [4] S, [3:0] type.
  - `hidBase` is used as the base and `hidLimit` as the effective limit.
- R10: `resValid` is high exactly in the cycle after a cycle with `reqValid` high. The result outputs change only then. After reset, all outputs are 0.
- R11: Error codes are 0 ok, 1 invalid selector, 2 not present and 3 out of bounds. With any nonzero code, `resLinear` and `resRemain` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tblWrEn | input | 1 | Table word write strobe |
| tblWrLocal | input | 1 | Write target: 1 local table, 0 global table |
| tblWrIdx | input | 5 | Descriptor index to write |
| tblWrHigh | input | 1 | 1 writes the high word, 0 the low word |
| tblWrData | input | 32 | Descriptor word |
| gdtBytes | input | 16 | Byte limit of the global table |
| ldtBytes | input | 16 | Byte limit of the local table |
| reqValid | input | 1 | Request strobe |
| reqSel | input | 16 | Selector |
| reqOffset | input | 32 | Offset |
| realMode | input | 1 | Real or virtual-8086 translation |
| hidValid | input | 1 | Hidden descriptor cache is valid |
| hidBase | input | 32 | Cached base |
| hidLimit | input | 32 | Cached effective limit |
| hidAttr | input | 7 | Cached attributes (see R9) |
| tblBypass | input | 1 | Skip the global table bound check |
| resValid | output | 1 | Result strobe |
| resLinear | output | 32 | Linear address |
| resRemain | output | 33 | Bytes reachable from the linear address |
| resErr | output | 2 | Error code (see R11) |

## Verification
The checker runs on every cycle and tests the following:
- the one-cycle request-to-result timing;
- that error results carry zero address and count;
- the real-mode count formula;
- the not-present error from the hidden cache;
- the global table bound fault;
- that any successful count lies between 1 and 2^32.

The bench's reference model is needed for what depends on table contents:
- the type classification, including every system type and expand-down segments;
- the granularity scaling and base assembly;
- local versus global table selection and the bypass interaction;
- address wraparound modulo 2^32.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int ADDR_W = 32;
  localparam int REM_W  = ADDR_W + 1;
  localparam int SEL_W  = 16;

  typedef enum logic [1:0] {
    SEG_OK      = 2'd0,
    SEG_BADSEL  = 2'd1,
    SEG_NOTPRES = 2'd2,
    SEG_BOUNDS  = 2'd3
  } segErr_t;

  typedef struct packed {
    logic       gran;
    logic       present;
    logic       descType;
    logic [3:0] segType;
  } segAttr_t;

  typedef struct packed {
    logic capture;
    logic realPath;
    logic realHidBase;
    logic hidPath;
    logic useLocal;
    logic boundFault;
  } segStrobe_t;

  function automatic logic sysTypeOk(input logic [3:0] t);
    return !(t == 4'h0 || t == 4'h8 || t == 4'hA || t == 4'hD);
  endfunction
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int ENTRIES = 32,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic          wrHigh,
  input  logic [31:0]   wrData,
  input  logic [IW-1:0] rdIdx,
  output logic [31:0]   rdLo,
  output logic [31:0]   rdHi
);
  logic [31:0] loMem [ENTRIES];
  logic [31:0] hiMem [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        loMem[i] <= '0;
        hiMem[i] <= '0;
      end
    end else if (wrEn) begin
      if (wrHigh) hiMem[wrIdx] <= wrData;
      else        loMem[wrIdx] <= wrData;
    end
  end

  assign rdLo = loMem[rdIdx];
  assign rdHi = hiMem[rdIdx];
endmodule

// File: rtl/seg_control.sv
module seg_control
  import segx_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int BYTES_W = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic               reqValid,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic               realMode,
  input  logic               hidValid,
  input  logic               tblBypass,
  input  logic [BYTES_W-1:0] gdtBytes,
  input  logic [BYTES_W-1:0] ldtBytes,
  output segStrobe_t         strb,
  output logic [IW-1:0]      rdIdx
);
  logic [SEL_W-1:0] maskedSel;
  logic [SEL_W-1:0] tblBytes;
  logic             overBound;

  always_comb begin
    maskedSel = {reqSel[SEL_W-1:3], 3'b000};
    tblBytes  = SEL_W'(reqSel[2] ? ldtBytes : gdtBytes);
    overBound = maskedSel >= tblBytes;

    strb.capture     = reqValid;
    strb.realPath    = realMode;
    strb.realHidBase = hidValid;
    strb.hidPath     = !realMode && hidValid;
    strb.useLocal    = reqSel[2];
    strb.boundFault  = !realMode && !hidValid && overBound
                       && (reqSel[2] || !tblBypass);
  end

  assign rdIdx = reqSel[3 +: IW];
endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import segx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  segStrobe_t        strb,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic [ADDR_W-1:0] hidBase,
  input  logic [ADDR_W-1:0] hidLimit,
  input  segAttr_t          hidAttr,
  input  logic [31:0]       descLo,
  input  logic [31:0]       descHi,
  output logic              resValid,
  output logic [ADDR_W-1:0] resLinear,
  output logic [REM_W-1:0]  resRemain,
  output logic [1:0]        resErr
);
  localparam logic [REM_W-1:0] ONE_R      = REM_W'(1);
  localparam logic [REM_W-1:0] DOWN_BIG   = REM_W'(33'h0_FFFF_FFFF);
  localparam logic [REM_W-1:0] DOWN_SMALL = REM_W'(33'h0_0000_FFFF);
  localparam logic [REM_W-1:0] FULL_SPAN  = REM_W'(33'h1_0000_0000);
  localparam logic [REM_W-1:0] PARA_SPAN  = REM_W'(33'h0_0001_0000);

  logic [ADDR_W-1:0] tBase, tLimit, selBase, selLimit, linear;
  logic [ADDR_W-1:0] realBase, realLinear;
  logic [19:0]       tRaw;
  segAttr_t          tAttr, attr;
  logic              expDown;
  logic [REM_W-1:0]  upRem, downRem, sysRem, realRem;
  segErr_t           nErr;
  logic [ADDR_W-1:0] nLin;
  logic [REM_W-1:0]  nRem;

  // descriptor field extraction and source selection
  always_comb begin
    tBase  = {descHi[31:24], descHi[7:0], descLo[31:16]};
    tRaw   = {descHi[19:16], descLo[15:0]};
    tAttr.gran     = descHi[23];
    tAttr.present  = descHi[15];
    tAttr.descType = descHi[12];
    tAttr.segType  = descHi[11:8];
    tLimit = tAttr.gran ? {tRaw, 12'hFFF} : {12'h000, tRaw};

    selBase  = strb.hidPath ? hidBase  : tBase;
    selLimit = strb.hidPath ? hidLimit : tLimit;
    attr     = strb.hidPath ? hidAttr  : tAttr;
    linear   = selBase + reqOffset;

    realBase   = strb.realHidBase ? hidBase : {12'h000, reqSel, 4'h0};
    realLinear = realBase + {16'h0000, reqOffset[15:0]};
  end

  // remaining-byte candidates
  always_comb begin
    upRem   = {1'b0, selLimit} - {1'b0, reqOffset} + ONE_R;
    downRem = (attr.gran ? DOWN_BIG : DOWN_SMALL) - {1'b0, reqOffset} + ONE_R;
    sysRem  = FULL_SPAN - {1'b0, linear};
    realRem = PARA_SPAN - {17'h0, reqOffset[15:0]};
    expDown = !attr.segType[3] && attr.segType[2];
  end

  // check ordering: mode, table bound, presence, type, limit
  always_comb begin
    nErr = SEG_OK;
    nLin = linear;
    nRem = '0;
    if (strb.realPath) begin
      nLin = realLinear;
      nRem = realRem;
    end else if (strb.boundFault) begin
      nErr = SEG_BADSEL;
    end else if (!attr.present) begin
      nErr = SEG_NOTPRES;
    end else if (attr.descType) begin
      if (expDown) begin
        if ((!attr.gran && reqOffset > 32'h0000_FFFF) || reqOffset <= selLimit)
          nErr = SEG_BOUNDS;
        else
          nRem = downRem;
      end else begin
        if (reqOffset > selLimit) nErr = SEG_BOUNDS;
        else                      nRem = upRem;
      end
    end else if (sysTypeOk(attr.segType)) begin
      if (reqOffset > selLimit) nErr = SEG_BOUNDS;
      else                      nRem = sysRem;
    end else begin
      nErr = SEG_BADSEL;
    end
    if (nErr != SEG_OK) begin
      nLin = '0;
      nRem = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resLinear <= '0;
      resRemain <= '0;
      resErr    <= 2'd0;
    end else begin
      resValid <= strb.capture;
      if (strb.capture) begin
        resLinear <= nLin;
        resRemain <= nRem;
        resErr    <= nErr;
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import segx_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int BYTES_W = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWrEn,
  input  logic               tblWrLocal,
  input  logic [IW-1:0]      tblWrIdx,
  input  logic               tblWrHigh,
  input  logic [31:0]        tblWrData,
  input  logic [BYTES_W-1:0] gdtBytes,
  input  logic [BYTES_W-1:0] ldtBytes,
  input  logic               reqValid,
  input  logic [15:0]        reqSel,
  input  logic [31:0]        reqOffset,
  input  logic               realMode,
  input  logic               hidValid,
  input  logic [31:0]        hidBase,
  input  logic [31:0]        hidLimit,
  input  logic [6:0]         hidAttr,
  input  logic               tblBypass,
  output logic               resValid,
  output logic [31:0]        resLinear,
  output logic [32:0]        resRemain,
  output logic [1:0]         resErr
);
  segStrobe_t    strb;
  logic [IW-1:0] rdIdx;
  logic [31:0]   tblLo [2];
  logic [31:0]   tblHi [2];

  seg_control #(.ENTRIES(ENTRIES), .BYTES_W(BYTES_W)) u_ctl (
    .reqValid (reqValid),
    .reqSel   (reqSel),
    .realMode (realMode),
    .hidValid (hidValid),
    .tblBypass(tblBypass),
    .gdtBytes (gdtBytes),
    .ldtBytes (ldtBytes),
    .strb     (strb),
    .rdIdx    (rdIdx)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tbl
    seg_desc_table #(.ENTRIES(ENTRIES)) u_tbl (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (tblWrEn && (tblWrLocal == (g == 1))),
      .wrIdx (tblWrIdx),
      .wrHigh(tblWrHigh),
      .wrData(tblWrData),
      .rdIdx (rdIdx),
      .rdLo  (tblLo[g]),
      .rdHi  (tblHi[g])
    );
  end

  seg_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqSel   (reqSel),
    .reqOffset(reqOffset),
    .hidBase  (hidBase),
    .hidLimit (hidLimit),
    .hidAttr  (segAttr_t'(hidAttr)),
    .descLo   (tblLo[strb.useLocal]),
    .descHi   (tblHi[strb.useLocal]),
    .resValid (resValid),
    .resLinear(resLinear),
    .resRemain(resRemain),
    .resErr   (resErr)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] gdtBytes,
  input logic        reqValid,
  input logic [15:0] reqSel,
  input logic [31:0] reqOffset,
  input logic        realMode,
  input logic        hidValid,
  input logic [6:0]  hidAttr,
  input logic        tblBypass,
  input logic        resValid,
  input logic [31:0] resLinear,
  input logic [32:0] resRemain,
  input logic [1:0]  resErr
);
  // R10
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  // R10
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
  // R11
  err_zeroes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resErr != 2'd0) |-> (resLinear == 32'h0 && resRemain == 33'h0));
  // R1
  real_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && realMode) |=>
      (resErr == 2'd0 && resRemain == 33'h1_0000 - {17'h0, $past(reqOffset[15:0])}));
  // R5
  hid_absent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !realMode && hidValid && !hidAttr[5]) |=> resErr == 2'd2);
  // R3
  gdt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !realMode && !hidValid && !reqSel[2] && !tblBypass
      && {reqSel[15:3], 3'b000} >= gdtBytes) |=> resErr == 2'd1);
  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resErr == 2'd0) |-> (resRemain != 33'h0 && resRemain <= 33'h1_0000_0000));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .gdtBytes (gdtBytes),
  .reqValid (reqValid),
  .reqSel   (reqSel),
  .reqOffset(reqOffset),
  .realMode (realMode),
  .hidValid (hidValid),
  .hidAttr  (hidAttr),
  .tblBypass(tblBypass),
  .resValid (resValid),
  .resLinear(resLinear),
  .resRemain(resRemain),
  .resErr   (resErr)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tblWrEn = 0, tblWrLocal = 0, tblWrHigh = 0;
  logic [4:0]  tblWrIdx = 0;
  logic [31:0] tblWrData = 0;
  logic [15:0] gdtBytes = 16'h0100, ldtBytes = 16'h0100;
  logic        reqValid = 0, realMode = 0, hidValid = 0, tblBypass = 0;
  logic [15:0] reqSel = 0;
  logic [31:0] reqOffset = 0, hidBase = 0, hidLimit = 0;
  logic [6:0]  hidAttr = 0;
  logic        resValid;
  logic [31:0] resLinear;
  logic [32:0] resRemain;
  logic [1:0]  resErr;

  int checkCount = 0, failCount = 0;
  bit done = 0;
  logic [31:0] rnd = 32'h1234_5678;

  always #2.5 clk = ~clk;

  seg_xlate dut (.*);

  // reference state
  logic [31:0] mLo [2][32];
  logic [31:0] mHi [2][32];
  bit          expValid = 0;
  logic [31:0] expLin = 0;
  logic [32:0] expRem = 0;
  logic [1:0]  expErr = 0;
  string       expTag = "R10";
  bit          comparing = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic modelReq(output logic [31:0] lin, output logic [32:0] rem,
                          output logic [1:0] err, output string tag);
    longint unsigned off, base, lim, raw, l, r, ms;
    bit P, S, G, fault;
    int T, t, idx;
    logic [31:0] lo, hi;
    off = longint'(reqOffset); err = 0; l = 0; r = 0; fault = 0;
    base = 0; lim = 0; P = 0; S = 0; G = 0; T = 0;
    if (realMode) begin
      base = hidValid ? longint'(hidBase) : longint'(reqSel) * 16;
      l = (base + (off & 64'hFFFF)) & 64'hFFFF_FFFF;
      r = 64'h1_0000 - (off & 64'hFFFF);
      tag = "R1";
    end else begin
      if (hidValid) begin
        base = hidBase; lim = hidLimit;
        G = hidAttr[6]; P = hidAttr[5]; S = hidAttr[4]; T = int'(hidAttr[3:0]);
        tag = "R9";
      end else begin
        t = int'(reqSel[2]); idx = (int'(reqSel) / 8) % 32; ms = (longint'(reqSel) / 8) * 8;
        lo = mLo[t][idx]; hi = mHi[t][idx];
        base = (longint'(hi[31:24]) << 24) + (longint'(hi[7:0]) << 16) + longint'(lo[31:16]);
        raw = (longint'(hi[19:16]) << 16) + longint'(lo[15:0]);
        G = hi[23]; P = hi[15]; S = hi[12]; T = int'(hi[11:8]);
        lim = G ? raw * 4096 + 4095 : raw;
        tag = (t == 1) ? "R2" : (G ? "R4" : "R6");
        if (ms >= longint'(t == 1 ? ldtBytes : gdtBytes) && (t == 1 || !tblBypass)) begin
          err = 1; tag = "R3"; fault = 1;
        end
      end
      if (!fault) begin
        l = (base + off) & 64'hFFFF_FFFF;
        if (!P) begin
          err = 2; tag = "R5";
        end else if (S) begin
          if (T >= 4 && T <= 7) begin
            tag = "R7";
            if ((!G && off > 64'hFFFF) || off <= lim) err = 3;
            else r = (G ? 64'hFFFF_FFFF : 64'hFFFF) - off + 1;
          end else begin
            if (off > lim) err = 3; else r = lim - off + 1;
          end
        end else begin
          tag = "R8";
          if (T == 0 || T == 8 || T == 10 || T == 13) err = 1;
          else if (off > lim) err = 3;
          else r = 64'h1_0000_0000 - l;
        end
      end
    end
    if (err != 0) begin l = 0; r = 0; tag = {tag, "/R11"}; end
    lin = l[31:0]; rem = r[32:0];
  endtask

  // cycle-accurate reference: result of this edge's request appears after it
  always @(posedge clk) begin
    if (!rstN) begin
      expValid = 0;
    end else begin
      expValid = reqValid;
      if (reqValid) modelReq(expLin, expRem, expErr, expTag);
      if (tblWrEn) begin
        if (tblWrHigh) mHi[tblWrLocal][tblWrIdx] = tblWrData;
        else           mLo[tblWrLocal][tblWrIdx] = tblWrData;
      end
    end
  end

  always @(negedge clk) begin
    if (comparing) begin
      check(resValid == expValid, "R10", "resValid", 64'(resValid), 64'(expValid));
      if (expValid) begin
        check(resErr == expErr, expTag, "resErr", 64'(resErr), 64'(expErr));
        check(resLinear == expLin, expTag, "resLinear", 64'(resLinear), 64'(expLin));
        check(resRemain == expRem, expTag, "resRemain", 64'(resRemain), 64'(expRem));
      end
    end
  end

  function automatic logic [31:0] nextRnd(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic genDesc(input int tbl, input int idx, output logic [31:0] lo,
                         output logic [31:0] hi, output longint unsigned lim);
    logic [31:0] base;
    logic [19:0] raw;
    logic G, P, S;
    base = (tbl == 1 ? 32'h4000_0000 : 32'h0010_0000) + 32'(idx) * 32'h0001_1000;
    if (idx == 7) base = 32'hFFFF_F000;
    raw = 20'(idx * 20'h01357 + tbl * 20'h00ABC);
    if (idx == 3) raw = 20'h000FF;
    G = (idx % 2 == 1) ^ (idx / 8 % 2 == 1);
    P = !(idx == 9 || idx == 22);
    S = (idx >= 16) ^ (tbl == 1);
    lo = {base[15:0], raw[15:0]};
    hi = {base[31:24], G, 1'b1, 2'b00, raw[19:16], P, 2'b00, S, 4'(idx), base[23:16]};
    lim = G ? longint'(raw) * 4096 + 4095 : longint'(raw);
  endtask

  task automatic wrWord(input int tbl, input int idx, input bit high, input logic [31:0] d);
    tblWrEn = 1; tblWrLocal = (tbl == 1); tblWrIdx = 5'(idx); tblWrHigh = high; tblWrData = d;
    @(negedge clk);
    tblWrEn = 0;
  endtask

  task automatic doReq(input logic [15:0] sel, input logic [31:0] off, input bit rm,
                       input bit hv, input logic [31:0] hb, input logic [31:0] hl,
                       input logic [6:0] ha);
    reqValid = 1; reqSel = sel; reqOffset = off; realMode = rm;
    hidValid = hv; hidBase = hb; hidLimit = hl; hidAttr = ha;
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] lo, hi;
    longint unsigned lim;
    longint unsigned offs [6];
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 32; i++) begin mLo[t][i] = 0; mHi[t][i] = 0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(resValid == 0 && resErr == 0, "R10", "reset valid/err", 64'({resValid, resErr}), 64'h0);
    check(resLinear == 0 && resRemain == 0, "R10", "reset data", 64'(resLinear) | 64'(resRemain), 64'h0);
    rstN = 1;
    comparing = 1;
    @(negedge clk);
    // load both tables
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 32; i++) begin
        genDesc(t, i, lo, hi, lim);
        wrWord(t, i, 0, lo);
        wrWord(t, i, 1, hi);
      end
    // sweep every descriptor at limit corners (R2 R4 R6 R7 R8 R5)
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 32; i++) begin
        genDesc(t, i, lo, hi, lim);
        offs[0] = 0; offs[1] = lim; offs[2] = lim + 1;
        offs[3] = 64'hFFFF; offs[4] = 64'h1_0000; offs[5] = 64'hFFFF_FFFF;
        for (int k = 0; k < 6; k++)
          doReq(16'((i << 3) | (t << 2) | (k % 4)), offs[k][31:0], 0, 0, 0, 0, 0);
      end
    // table bounds and bypass (R3)
    gdtBytes = 16'h00F8; ldtBytes = 16'h00C0;
    doReq(16'h00F8, 32'h0, 0, 0, 0, 0, 0);
    tblBypass = 1;
    doReq(16'h00F8, 32'h0, 0, 0, 0, 0, 0);
    doReq(16'h01F0, 32'h10, 0, 0, 0, 0, 0);
    doReq(16'h00C4, 32'h0, 0, 0, 0, 0, 0);
    tblBypass = 0;
    doReq(16'h00BC, 32'h0, 0, 0, 0, 0, 0);
    doReq(16'h00F0, 32'h0, 0, 0, 0, 0, 0);
    // real mode (R1)
    doReq(16'h1234, 32'h0001_FFFF, 1, 0, 0, 0, 0);
    doReq(16'hFFFF, 32'h0000_FFF0, 1, 0, 0, 0, 0);
    doReq(16'h0000, 32'h0, 1, 1, 32'hFFFF_FFF0, 0, 0);
    // hidden cache (R9): expand-up, expand-down, absent, rejected system
    doReq(16'h00F8, 32'h100, 0, 1, 32'h8000_0000, 32'h0000_0FFF, 7'b0110010);
    doReq(16'h00F8, 32'h2000, 0, 1, 32'h0, 32'h0000_0FFF, 7'b0110110);
    doReq(16'h0000, 32'h0, 0, 1, 32'h0, 32'hFFFF_FFFF, 7'b1010010);
    doReq(16'h0000, 32'h0, 0, 1, 32'h0, 32'hFFFF_FFFF, 7'b0101000);
    doReq(16'h0000, 32'h10, 0, 1, 32'h1000, 32'hFFFF_FFFF, 7'b0101001);
    // back-to-back random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] sel;
      logic [31:0] off;
      int mode;
      rnd = nextRnd(rnd); sel = rnd[15:0];
      if (rnd[16]) sel = {8'h00, sel[7:0]};
      tblBypass = rnd[17];
      if (rnd[23:20] == 0) begin gdtBytes = {8'h0, rnd[31:24]}; ldtBytes = {8'h0, rnd[31:26], 2'b00}; end
      mode = int'(rnd[19:18]);
      genDesc(int'(sel[2]), int'(sel[7:3]), lo, hi, lim);
      rnd = nextRnd(rnd);
      case (mode)
        0: off = {20'h0, rnd[11:0]};
        1: off = {15'h0, rnd[16:0]};
        2: off = rnd;
        default: off = 32'(lim + 64'(rnd[1:0]) - 1);
      endcase
      rnd = nextRnd(rnd);
      if (rnd[0]) begin
        doReq(sel, off, rnd[1] & rnd[2], rnd[3] & rnd[4], nextRnd(rnd), {12'h0, rnd[27:8]}, rnd[14:8]);
      end else begin
        doReq(sel, off, rnd[1] & rnd[2], 0, 0, 0, 0);
      end
      if (rnd[5]) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule